// File: doc/BRIEF.md
# System Control Register Bank with Privilege Gating

This block holds the 32-bit system control registers that a processor core reaches through its move-to-coprocessor and move-from-coprocessor operations. Every access names a register by a four-field tuple: a primary register number `crn` (4 bits), a first opcode `op1` (3 bits), a secondary register number `crm` (4 bits) and a second opcode `op2` (3 bits). The bank has a separate read port and write port. Each port carries its own tuple, and both share a single privileged/user mode input.

Read data comes back combinationally in the same cycle. Writes take effect at the next rising clock edge. Identification registers are constants set by parameters.

Some writes target cache-maintenance, barrier, TLB-invalidate or lockdown-entry operations. These registers keep no state. A write to one produces a one-cycle strobe that carries an operation code and the written data, so that the logic that performs the operation can act on it. Any access that names a tuple the bank does not implement, or that the current mode may not perform, changes nothing and raises a one-cycle error pulse.

Top module: `sysreg_bank`

## Requirements
- R1: After reset every writable register reads zero, and `err_o` and `op_valid_o` are low.
- R2: A privileged write to a storage register is returned by a later privileged read of the same tuple. The whole tuple selects the register: (1,0,0,0), (1,0,0,1) and (1,0,0,2) are three distinct registers, and (1,1,0,0) is not implemented.
- R3: In user mode only two reads succeed: (13,0,0,2), the user read/write thread ID, and (13,0,0,3). Every other user read returns zero and raises the error pulse.
- R4: A read of (13,0,0,3) returns the parameter `URO_CONST` in both modes, even after a write to that tuple.
- R5: In user mode only four writes succeed: (7,0,5,4) prefetch flush, (7,0,10,4) synchronization barrier, (7,0,10,5) memory barrier and (13,0,0,2) thread ID. Any other user write leaves all state unchanged and raises the error pulse.
- R6: The thread-ID registers (13,0,0,3) and (13,0,0,4) accept writes only in privileged mode. (13,0,0,4) can be read only in privileged mode.
- R7: A read of an unimplemented tuple returns zero. A write to an unimplemented tuple changes no state. Either raises `err_o` for exactly the cycle after the access.
- R8: A permitted write to an operation register raises `op_valid_o` for exactly the following cycle. In that cycle `op_data_o` holds the written data and `op_code_o = {class[1:0], crm[3:0], op2[2:0]}`, where class is 0 for `crn`=7, 1 for `crn`=8 (with `crm` 5/6/7 naming the instruction, data or unified TLB and `op2` 0..3) and 2 for (15,5,4,2/4). Operation registers are write-only: reading one returns zero and raises the error pulse.
- R9: Identification registers are read-only and return parameter values. Their values are: (0,0,0,0) `MAIN_ID`; (0,0,0,1) `CACHE_TYPE`; (0,0,0,3) `TLB_TYPE`; (0,0,0,5) `CORE_NUM`; and `FEAT_BASE`+k for the feature registers. The feature registers, in order k=0..11, are (0,0,1,op2) for op2 in 0,1,2,4,5,6,7 and then (0,0,2,op2) for op2 in 0..4. A write to any of them is ignored and raises the error pulse.
- R10: When `crn`=15, `op1` takes part in selection. (15,0,12,0..3) are the monitor control register, the cycle counter and two event counters. (15,5,5/6/7,2) are the lockdown address and attribute registers. (15,7,1,0) is the TLB debug control register. Any other `op1` is unimplemented.
- R11: A read in the same cycle as a write to the same register returns the old value. The new value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| priv_i | input | 1 | 1 = privileged mode, 0 = user mode |
| rd_en_i | input | 1 | Read request |
| rd_crn_i | input | 4 | Read tuple primary register |
| rd_op1_i | input | 3 | Read tuple first opcode |
| rd_crm_i | input | 4 | Read tuple secondary register |
| rd_op2_i | input | 3 | Read tuple second opcode |
| rd_data_o | output | DATA_W | Read data, same cycle, zero when the read is refused |
| wr_en_i | input | 1 | Write request |
| wr_crn_i | input | 4 | Write tuple primary register |
| wr_op1_i | input | 3 | Write tuple first opcode |
| wr_crm_i | input | 4 | Write tuple secondary register |
| wr_op2_i | input | 3 | Write tuple second opcode |
| wr_data_i | input | DATA_W | Write data |
| op_valid_o | output | 1 | One-cycle operation strobe |
| op_code_o | output | 9 | Operation code {class, crm, op2} |
| op_data_o | output | DATA_W | Data written to the operation register |
| err_o | output | 1 | One-cycle error pulse for a refused access |

## Verification
A wrong decode or a faulty store makes a later read of the same tuple return a value that differs from the last permitted write. This shows on `rd_data_o` in the first read after the corrupting edge. A privilege leak shows the same way: a user-mode read returns a nonzero value, or a refused write changes a register that a later privileged read returns. A misrouted strobe or error shows one cycle after the access, either on `op_valid_o`/`op_code_o` or as a missing or extra `err_o` pulse. For that reason the bench follows every write with reads of both the target tuple and its neighbours.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

   localparam int TUP_CRN_W = 4;
   localparam int TUP_OP1_W = 3;
   localparam int TUP_CRM_W = 4;
   localparam int TUP_OP2_W = 3;
   localparam int IDX_W     = 5;
   localparam int OPC_W     = 2 + TUP_CRM_W + TUP_OP2_W;

   typedef enum logic [2:0] {K_NONE, K_STORE, K_ID, K_CONST, K_OP} kind_e;

   // storage slots
   localparam logic [IDX_W-1:0] S_CTRL = 5'd0,  S_TTB0 = 5'd3,  S_DACR = 5'd6,
                                S_DFSR = 5'd7,  S_FAR  = 5'd9,  S_PAR  = 5'd11,
                                S_DCLK = 5'd12, S_TLBL = 5'd13, S_PRRR = 5'd14,
                                S_PID  = 5'd16, S_TURW = 5'd18, S_TURO = 5'd19,
                                S_TPRW = 5'd20, S_PMC  = 5'd21, S_LKVA = 5'd25,
                                S_TDBG = 5'd28;
   localparam int N_STORE = 29;
   localparam int N_ID    = 16;
   localparam int N_FEAT  = N_ID - 4;

   typedef struct packed {
      kind_e              kind;
      logic [IDX_W-1:0]   idx;
      logic               user_rd;
      logic               user_wr;
      logic [OPC_W-1:0]   opc;
   } dec_t;

   function automatic dec_t tuple_decode(input logic [3:0] crn, input logic [2:0] op1,
                                         input logic [3:0] crm, input logic [2:0] op2);
      dec_t d;
      d = '{kind: K_NONE, idx: '0, user_rd: 1'b0, user_wr: 1'b0, opc: '0};
      if (op1 == 3'd0) begin
         case (crn)
            4'd0: begin
               if (crm == 4'd0 && (op2 == 3'd0 || op2 == 3'd1 || op2 == 3'd3 || op2 == 3'd5))
                  begin d.kind = K_ID; d.idx = (op2 == 3'd0) ? 5'd0 : (op2 == 3'd1) ? 5'd1 :
                                                 (op2 == 3'd3) ? 5'd2 : 5'd3; end
               else if (crm == 4'd1 && op2 != 3'd3)
                  begin d.kind = K_ID; d.idx = 5'd4 + 5'(op2) - ((op2 > 3'd3) ? 5'd1 : 5'd0); end
               else if (crm == 4'd2 && op2 <= 3'd4)
                  begin d.kind = K_ID; d.idx = 5'd11 + 5'(op2); end
            end
            4'd1: if (crm == 4'd0 && op2 <= 3'd2) begin d.kind = K_STORE; d.idx = S_CTRL + 5'(op2); end
            4'd2: if (crm == 4'd0 && op2 <= 3'd2) begin d.kind = K_STORE; d.idx = S_TTB0 + 5'(op2); end
            4'd3: if (crm == 4'd0 && op2 == 3'd0) begin d.kind = K_STORE; d.idx = S_DACR; end
            4'd5: if (crm == 4'd0 && op2 <= 3'd1) begin d.kind = K_STORE; d.idx = S_DFSR + 5'(op2); end
            4'd6: if (crm == 4'd0 && op2 <= 3'd1) begin d.kind = K_STORE; d.idx = S_FAR + 5'(op2); end
            4'd7: begin
               if (crm == 4'd4 && op2 == 3'd0) begin d.kind = K_STORE; d.idx = S_PAR; end
               else if ((crm == 4'd0 && op2 == 3'd4) ||
                        (crm == 4'd5 && op2 != 3'd3 && op2 != 3'd5) ||
                        ((crm == 4'd6 || crm == 4'd14) && op2 <= 3'd2) ||
                        (crm == 4'd7 && op2 == 3'd0) ||
                        (crm == 4'd10 && op2 <= 3'd5 && op2 != 3'd3)) begin
                  d.kind    = K_OP;
                  d.opc     = {2'd0, crm, op2};
                  d.user_wr = (crm == 4'd5 && op2 == 3'd4) || (crm == 4'd10 && op2 >= 3'd4);
               end
            end
            4'd8: if (crm >= 4'd5 && crm <= 4'd7 && op2 <= 3'd3) begin
               d.kind = K_OP; d.opc = {2'd1, crm, op2};
            end
            4'd9:  if (crm == 4'd0 && op2 == 3'd0) begin d.kind = K_STORE; d.idx = S_DCLK; end
            4'd10: begin
               if (crm == 4'd0 && op2 == 3'd0) begin d.kind = K_STORE; d.idx = S_TLBL; end
               else if (crm == 4'd2 && op2 <= 3'd1) begin d.kind = K_STORE; d.idx = S_PRRR + 5'(op2); end
            end
            4'd13: if (crm == 4'd0 && op2 <= 3'd4) begin
               d.kind = (op2 == 3'd3) ? K_CONST : K_STORE;
               d.idx  = S_PID + 5'(op2);
               d.user_rd = (op2 == 3'd2) || (op2 == 3'd3);
               d.user_wr = (op2 == 3'd2);
            end
            4'd15: if (crm == 4'd12 && op2 <= 3'd3) begin d.kind = K_STORE; d.idx = S_PMC + 5'(op2); end
            default: ;
         endcase
      end else if (crn == 4'd15 && op1 == 3'd5) begin
         if (crm == 4'd4 && (op2 == 3'd2 || op2 == 3'd4)) begin d.kind = K_OP; d.opc = {2'd2, crm, op2}; end
         else if (crm >= 4'd5 && crm <= 4'd7 && op2 == 3'd2) begin
            d.kind = K_STORE; d.idx = S_LKVA + 5'(crm - 4'd5);
         end
      end else if (crn == 4'd15 && op1 == 3'd7 && crm == 4'd1 && op2 == 3'd0) begin
         d.kind = K_STORE; d.idx = S_TDBG;
      end
      return d;
   endfunction

endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
   import sysreg_pkg::*;
#(
   parameter bit IS_WRITE = 1'b0
)(
   input  logic [3:0]       crn_i,
   input  logic [2:0]       op1_i,
   input  logic [3:0]       crm_i,
   input  logic [2:0]       op2_i,
   input  logic             priv_i,
   output kind_e            kind_o,
   output logic [IDX_W-1:0] idx_o,
   output logic [OPC_W-1:0] opc_o,
   output logic             ok_o
);
   dec_t d;
   assign d      = tuple_decode(crn_i, op1_i, crm_i, op2_i);
   assign kind_o = d.kind;
   assign idx_o  = d.idx;
   assign opc_o  = d.opc;

   generate
      if (IS_WRITE) begin : g_wr
         assign ok_o = (d.kind == K_STORE || d.kind == K_CONST || d.kind == K_OP) &&
                       (priv_i || d.user_wr);
      end else begin : g_rd
         assign ok_o = (d.kind == K_STORE || d.kind == K_ID || d.kind == K_CONST) &&
                       (priv_i || d.user_rd);
      end
   endgenerate
endmodule

// File: rtl/sysreg_idrom.sv
module sysreg_idrom
   import sysreg_pkg::*;
#(
   parameter int          DATA_W     = 32,
   parameter logic [DATA_W-1:0] MAIN_ID    = '0,
   parameter logic [DATA_W-1:0] CACHE_TYPE = '0,
   parameter logic [DATA_W-1:0] TLB_TYPE   = '0,
   parameter logic [DATA_W-1:0] CORE_NUM   = '0,
   parameter logic [DATA_W-1:0] FEAT_BASE  = '0
)(
   input  logic [IDX_W-1:0]  idx_i,
   output logic [DATA_W-1:0] val_o
);
   logic [DATA_W-1:0] rom [N_ID];

   assign rom[0] = MAIN_ID;
   assign rom[1] = CACHE_TYPE;
   assign rom[2] = TLB_TYPE;
   assign rom[3] = CORE_NUM;
   generate
      for (genvar k = 0; k < N_FEAT; k++) begin : g_feat
         assign rom[4+k] = FEAT_BASE + DATA_W'(k);
      end
   endgenerate

   assign val_o = (32'(idx_i) < N_ID) ? rom[idx_i[3:0]] : '0;
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
   import sysreg_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = N_STORE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [IDX_W-1:0]  widx_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [IDX_W-1:0]  ridx_i,
   output logic [DATA_W-1:0] rdata_o
);
   logic [DATA_W-1:0] q [DEPTH];
   logic [DEPTH-1:0]  hit;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_slot
         assign hit[i] = we_i && (widx_i == IDX_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      q[i] <= '0;
            else if (hit[i]) q[i] <= wdata_i;
         end
      end
   endgenerate

   assign rdata_o = (32'(ridx_i) < DEPTH) ? q[ridx_i] : '0;

   // R2: a write lands in at most one slot
   a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
   import sysreg_pkg::*;
#(
   parameter int                DATA_W     = 32,
   parameter logic [DATA_W-1:0] MAIN_ID    = 32'h1234_0001,
   parameter logic [DATA_W-1:0] CACHE_TYPE = 32'h0000_2222,
   parameter logic [DATA_W-1:0] TLB_TYPE   = 32'h0000_0800,
   parameter logic [DATA_W-1:0] CORE_NUM   = 32'h0000_0003,
   parameter logic [DATA_W-1:0] FEAT_BASE  = 32'h0100_0000,
   parameter logic [DATA_W-1:0] URO_CONST  = 32'hFFFF_0000
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              priv_i,
   input  logic              rd_en_i,
   input  logic [3:0]        rd_crn_i,
   input  logic [2:0]        rd_op1_i,
   input  logic [3:0]        rd_crm_i,
   input  logic [2:0]        rd_op2_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic              wr_en_i,
   input  logic [3:0]        wr_crn_i,
   input  logic [2:0]        wr_op1_i,
   input  logic [3:0]        wr_crm_i,
   input  logic [2:0]        wr_op2_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              op_valid_o,
   output logic [OPC_W-1:0]  op_code_o,
   output logic [DATA_W-1:0] op_data_o,
   output logic              err_o
);
   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("sysreg_bank: DATA_W must be at least 8");
      end
   endgenerate

   kind_e             rd_kind, wr_kind;
   logic [IDX_W-1:0]  rd_idx, wr_idx;
   logic [OPC_W-1:0]  rd_opc_unused, wr_opc;
   logic              rd_ok, wr_ok;
   logic [DATA_W-1:0] store_val, id_val;
   logic              store_we;

   sysreg_decode #(.IS_WRITE(1'b0)) u_rd_dec (
      .crn_i(rd_crn_i), .op1_i(rd_op1_i), .crm_i(rd_crm_i), .op2_i(rd_op2_i),
      .priv_i(priv_i), .kind_o(rd_kind), .idx_o(rd_idx), .opc_o(rd_opc_unused), .ok_o(rd_ok));

   sysreg_decode #(.IS_WRITE(1'b1)) u_wr_dec (
      .crn_i(wr_crn_i), .op1_i(wr_op1_i), .crm_i(wr_crm_i), .op2_i(wr_op2_i),
      .priv_i(priv_i), .kind_o(wr_kind), .idx_o(wr_idx), .opc_o(wr_opc), .ok_o(wr_ok));

   assign store_we = wr_en_i && wr_ok && (wr_kind == K_STORE || wr_kind == K_CONST);

   sysreg_store #(.DATA_W(DATA_W), .DEPTH(N_STORE)) u_store (
      .clk(clk), .rst_n(rst_n), .we_i(store_we), .widx_i(wr_idx), .wdata_i(wr_data_i),
      .ridx_i(rd_idx), .rdata_o(store_val));

   sysreg_idrom #(.DATA_W(DATA_W), .MAIN_ID(MAIN_ID), .CACHE_TYPE(CACHE_TYPE),
                  .TLB_TYPE(TLB_TYPE), .CORE_NUM(CORE_NUM), .FEAT_BASE(FEAT_BASE)) u_idrom (
      .idx_i(rd_idx), .val_o(id_val));

   always_comb begin
      rd_data_o = '0;
      if (rd_en_i && rd_ok) begin
         case (rd_kind)
            K_STORE: rd_data_o = store_val;
            K_ID:    rd_data_o = id_val;
            K_CONST: rd_data_o = URO_CONST;
            default: rd_data_o = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_valid_o <= 1'b0;
         op_code_o  <= '0;
         op_data_o  <= '0;
         err_o      <= 1'b0;
      end else begin
         op_valid_o <= wr_en_i && wr_ok && (wr_kind == K_OP);
         if (wr_en_i && wr_ok && wr_kind == K_OP) begin
            op_code_o <= wr_opc;
            op_data_o <= wr_data_i;
         end
         err_o <= (rd_en_i && !rd_ok) || (wr_en_i && !wr_ok);
      end
   end

   // R3: user reads outside the whitelist return zero
   a_r3_user_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && !priv_i && !(rd_crn_i == 4'd13 && rd_op1_i == 3'd0 && rd_crm_i == 4'd0 &&
        (rd_op2_i == 3'd2 || rd_op2_i == 3'd3))) |-> rd_data_o == '0);
   // R4: constant thread ID read in any mode
   a_r4_const_read: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_crn_i == 4'd13 && rd_op1_i == 3'd0 && rd_crm_i == 4'd0 && rd_op2_i == 3'd3)
      |-> rd_data_o == URO_CONST);
   // R7: unimplemented read returns zero
   a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && rd_kind == K_NONE) |-> rd_data_o == '0);
   // R5: user writes to TLB operations never strobe
   a_r5_user_no_tlb_op: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !priv_i && wr_crn_i == 4'd8) |=> !op_valid_o);
   // R8: a strobe always follows a write request
   a_r8_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid_o |-> $past(wr_en_i));
   // R7: an error pulse always follows an access
   a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(rd_en_i || wr_en_i));
endmodule

// File: tb/tb_sysreg_bank.sv
module tb_sysreg_bank;
   localparam logic [31:0] MAIN_ID   = 32'h1234_0001;
   localparam logic [31:0] FEAT_BASE = 32'h0100_0000;
   localparam logic [31:0] URO_CONST = 32'hFFFF_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic priv = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
   logic [3:0] rd_crn = '0, rd_crm = '0, wr_crn = '0, wr_crm = '0;
   logic [2:0] rd_op1 = '0, rd_op2 = '0, wr_op1 = '0, wr_op2 = '0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data, op_data;
   logic [8:0]  op_code;
   logic        op_valid, err;

   int checks = 0, errors = 0;
   bit done = 1'b0;
   logic [31:0] got_rd, got_opd;
   logic [8:0]  got_opc;
   logic        got_err, got_opv;

   always #5 clk = ~clk;

   sysreg_bank dut (
      .clk(clk), .rst_n(rst_n), .priv_i(priv),
      .rd_en_i(rd_en), .rd_crn_i(rd_crn), .rd_op1_i(rd_op1), .rd_crm_i(rd_crm), .rd_op2_i(rd_op2),
      .rd_data_o(rd_data),
      .wr_en_i(wr_en), .wr_crn_i(wr_crn), .wr_op1_i(wr_op1), .wr_crm_i(wr_crm), .wr_op2_i(wr_op2),
      .wr_data_i(wr_data),
      .op_valid_o(op_valid), .op_code_o(op_code), .op_data_o(op_data), .err_o(err));

   typedef struct packed {
      logic pv; logic wr;
      logic [3:0] crn; logic [2:0] op1; logic [3:0] crm; logic [2:0] op2;
      logic [31:0] dat; logic [31:0] exp; logic eerr;
   } vec_t;

   localparam int NV = 39;
   localparam vec_t TAB [NV] = '{
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd0,32'h0,32'h0,1'b0},                 // R1 reset value
      '{1'b1,1'b1,4'd1,3'd0,4'd0,3'd0,32'hA5A5_0001,32'h0,1'b0},         // R2
      '{1'b1,1'b1,4'd1,3'd0,4'd0,3'd1,32'h0000_00F1,32'h0,1'b0},         // R2
      '{1'b1,1'b1,4'd1,3'd0,4'd0,3'd2,32'h00F0_0000,32'h0,1'b0},         // R2
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd0,32'h0,32'hA5A5_0001,1'b0},         // R2
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd1,32'h0,32'h0000_00F1,1'b0},         // R2
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd2,32'h0,32'h00F0_0000,1'b0},         // R2
      '{1'b1,1'b0,4'd1,3'd1,4'd0,3'd0,32'h0,32'h0,1'b1},                 // R2 op1 differs
      '{1'b1,1'b1,4'd1,3'd1,4'd0,3'd0,32'h0000_DEAD,32'h0,1'b1},         // R7
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd0,32'h0,32'hA5A5_0001,1'b0},         // R7 unchanged
      '{1'b0,1'b0,4'd1,3'd0,4'd0,3'd0,32'h0,32'h0,1'b1},                 // R3
      '{1'b0,1'b1,4'd1,3'd0,4'd0,3'd0,32'h0000_1111,32'h0,1'b1},         // R5
      '{1'b1,1'b0,4'd1,3'd0,4'd0,3'd0,32'h0,32'hA5A5_0001,1'b0},         // R5 unchanged
      '{1'b0,1'b1,4'd13,3'd0,4'd0,3'd2,32'hCAFE_0002,32'h0,1'b0},        // R5
      '{1'b0,1'b0,4'd13,3'd0,4'd0,3'd2,32'h0,32'hCAFE_0002,1'b0},        // R3
      '{1'b1,1'b0,4'd13,3'd0,4'd0,3'd2,32'h0,32'hCAFE_0002,1'b0},        // R3
      '{1'b0,1'b0,4'd13,3'd0,4'd0,3'd3,32'h0,URO_CONST,1'b0},            // R4
      '{1'b1,1'b1,4'd13,3'd0,4'd0,3'd3,32'h0000_1234,32'h0,1'b0},        // R6
      '{1'b1,1'b0,4'd13,3'd0,4'd0,3'd3,32'h0,URO_CONST,1'b0},            // R4
      '{1'b0,1'b1,4'd13,3'd0,4'd0,3'd4,32'h0000_BEEF,32'h0,1'b1},        // R6
      '{1'b1,1'b0,4'd13,3'd0,4'd0,3'd4,32'h0,32'h0,1'b0},                // R6
      '{1'b1,1'b1,4'd13,3'd0,4'd0,3'd4,32'h0000_BEEF,32'h0,1'b0},        // R6
      '{1'b1,1'b0,4'd13,3'd0,4'd0,3'd4,32'h0,32'h0000_BEEF,1'b0},        // R6
      '{1'b0,1'b0,4'd13,3'd0,4'd0,3'd4,32'h0,32'h0,1'b1},                // R6
      '{1'b1,1'b0,4'd0,3'd0,4'd0,3'd0,32'h0,MAIN_ID,1'b0},               // R9
      '{1'b1,1'b1,4'd0,3'd0,4'd0,3'd0,32'h0,32'h0,1'b1},                 // R9
      '{1'b1,1'b0,4'd0,3'd0,4'd0,3'd0,32'h0,MAIN_ID,1'b0},               // R9
      '{1'b1,1'b0,4'd0,3'd0,4'd2,3'd4,32'h0,FEAT_BASE+32'd11,1'b0},      // R9
      '{1'b1,1'b0,4'd0,3'd0,4'd1,3'd4,32'h0,FEAT_BASE+32'd3,1'b0},       // R9
      '{1'b1,1'b0,4'd0,3'd0,4'd1,3'd3,32'h0,32'h0,1'b1},                 // R7
      '{1'b1,1'b1,4'd15,3'd0,4'd12,3'd1,32'h0000_0C0C,32'h0,1'b0},       // R10
      '{1'b1,1'b1,4'd15,3'd5,4'd5,3'd2,32'h0000_5A5A,32'h0,1'b0},        // R10
      '{1'b1,1'b1,4'd15,3'd7,4'd1,3'd0,32'h0000_0007,32'h0,1'b0},        // R10
      '{1'b1,1'b0,4'd15,3'd0,4'd12,3'd1,32'h0,32'h0000_0C0C,1'b0},       // R10
      '{1'b1,1'b0,4'd15,3'd5,4'd5,3'd2,32'h0,32'h0000_5A5A,1'b0},        // R10
      '{1'b1,1'b0,4'd15,3'd7,4'd1,3'd0,32'h0,32'h0000_0007,1'b0},        // R10
      '{1'b1,1'b0,4'd15,3'd1,4'd12,3'd1,32'h0,32'h0,1'b1},               // R10
      '{1'b1,1'b0,4'd6,3'd0,4'd0,3'd1,32'h0,32'h0,1'b0},                 // R1
      '{1'b1,1'b0,4'd3,3'd0,4'd0,3'd0,32'h0,32'h0,1'b0}                  // R1
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called away from the rising edge; returns after the following edge
   task automatic acc(input logic pv, input logic rd, input logic wr,
                      input logic [3:0] crn, input logic [2:0] op1,
                      input logic [3:0] crm, input logic [2:0] op2, input logic [31:0] dat);
      priv = pv; rd_en = rd; wr_en = wr;
      rd_crn = crn; rd_op1 = op1; rd_crm = crm; rd_op2 = op2;
      wr_crn = crn; wr_op1 = op1; wr_crm = crm; wr_op2 = op2; wr_data = dat;
      #1 got_rd = rd_data;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      #1;
      got_err = err; got_opv = op_valid; got_opc = op_code; got_opd = op_data;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R1 err after reset", {31'b0, err}, 32'h0);
      chk("R1 op_valid after reset", {31'b0, op_valid}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         acc(TAB[i].pv, !TAB[i].wr, TAB[i].wr, TAB[i].crn, TAB[i].op1, TAB[i].crm, TAB[i].op2, TAB[i].dat);
         if (!TAB[i].wr) chk($sformatf("vector %0d read data", i), got_rd, TAB[i].exp);
         chk($sformatf("vector %0d err", i), {31'b0, got_err}, {31'b0, TAB[i].eerr});
      end

      // R8: privileged data TLB invalidate by MVA
      acc(1'b1, 1'b0, 1'b1, 4'd8, 3'd0, 4'd6, 3'd3, 32'h0000_1000);
      chk("R8 strobe", {31'b0, got_opv}, 32'h1);
      chk("R8 code", {23'b0, got_opc}, {23'b0, 2'd1, 4'd6, 3'd3});
      chk("R8 data", got_opd, 32'h0000_1000);
      chk("R8 no error", {31'b0, got_err}, 32'h0);
      acc(1'b1, 1'b0, 1'b0, 4'd0, 3'd0, 4'd0, 3'd0, 32'h0);
      chk("R8 strobe one cycle", {31'b0, got_opv}, 32'h0);
      // R5: user memory barrier and prefetch flush
      acc(1'b0, 1'b0, 1'b1, 4'd7, 3'd0, 4'd10, 3'd5, 32'h0000_0055);
      chk("R5 user barrier strobe", {31'b0, got_opv}, 32'h1);
      chk("R5 user barrier code", {23'b0, got_opc}, {23'b0, 2'd0, 4'd10, 3'd5});
      acc(1'b0, 1'b0, 1'b1, 4'd7, 3'd0, 4'd5, 3'd4, 32'h0000_0044);
      chk("R5 user flush strobe", {31'b0, got_opv}, 32'h1);
      chk("R5 user flush data", got_opd, 32'h0000_0044);
      // R5: user TLB invalidate refused
      acc(1'b0, 1'b0, 1'b1, 4'd8, 3'd0, 4'd7, 3'd0, 32'h0000_0066);
      chk("R5 user tlb no strobe", {31'b0, got_opv}, 32'h0);
      chk("R5 user tlb error", {31'b0, got_err}, 32'h1);
      // R8: lockdown entry write, class 2
      acc(1'b1, 1'b0, 1'b1, 4'd15, 3'd5, 4'd4, 3'd4, 32'h0000_0ABC);
      chk("R8 lockdown code", {23'b0, got_opc}, {23'b0, 2'd2, 4'd4, 3'd4});
      // R8: operation register is write-only
      acc(1'b1, 1'b1, 1'b0, 4'd8, 3'd0, 4'd6, 3'd0, 32'h0);
      chk("R8 op read data", got_rd, 32'h0);
      chk("R8 op read error", {31'b0, got_err}, 32'h1);

      // R11: read and write same register in one cycle
      acc(1'b1, 1'b1, 1'b1, 4'd1, 3'd0, 4'd0, 3'd0, 32'h0000_0077);
      chk("R11 old value during write", got_rd, 32'hA5A5_0001);
      acc(1'b1, 1'b1, 1'b0, 4'd1, 3'd0, 4'd0, 3'd0, 32'h0);
      chk("R11 new value after edge", got_rd, 32'h0000_0077);

      // R1: reset clears stored state
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      acc(1'b1, 1'b1, 1'b0, 4'd1, 3'd0, 4'd0, 3'd0, 32'h0);
      chk("R1 control after reset", got_rd, 32'h0);
      acc(1'b1, 1'b1, 1'b0, 4'd13, 3'd0, 4'd0, 3'd2, 32'h0);
      chk("R1 thread id after reset", got_rd, 32'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule